// File: doc/BRIEF.md
# Fused multiply-add special-operand resolver

This combinational block sits ahead of a double-precision fused multiply-add datapath that evaluates `z + x*y`. It classifies each of the three raw operands from its bits. The classes are zero, normal, subnormal, infinity, quiet NaN and signaling NaN. From the three classes it applies a fixed priority to decide whether the answer is already known without arithmetic.

When the answer is known, the block drives the final 64-bit encoding and an invalid-operation flag, and holds `compute_o` low. When it is not known, it raises `compute_o` and tells the arithmetic stage which operands are subnormal and need normalizing first.

A build-time option treats every subnormal input as a zero of the same sign. Under that option, an operand that is passed through unchanged comes out as that signed zero.

Top module: `fma_special_resolve`

## Requirements
- R1: Operand classification uses the exponent field (bits 62:52), the fraction (bits 51:0) and the quiet bit (fraction bit 51):
  - An all-ones exponent with a zero fraction is infinity.
  - An all-ones exponent with a nonzero fraction is a quiet NaN when bit 51 is set and a signaling NaN when it is clear.
  - A zero exponent is zero when the fraction is zero and subnormal when it is not.
  - Any other exponent is normal.
- R2: A signaling-NaN addend `z` beats every other case. The result is `z` with bit 51 set, `invalid_o` is 1 and `compute_o` is 0.
- R3: Otherwise, a signaling NaN in `x` gives `x` with bit 51 set and `invalid_o` = 1. This holds whatever `y` is.
- R4: Otherwise, a signaling NaN in `y` gives `y` with bit 51 set and `invalid_o` = 1.
- R5: With no signaling NaN present, a quiet NaN in `x` is returned bit for bit. Failing that, a quiet NaN in `y` is returned bit for bit. Both outrank a quiet-NaN addend, and `invalid_o` is 0.
- R6: Infinity times zero, in either order, returns a quiet-NaN addend unchanged with `invalid_o` = 0. Otherwise it returns 0x7FF8000000000000 with `invalid_o` = 1.
- R7: For any other infinite product, a quiet-NaN addend is returned unchanged. Otherwise the result is infinity with sign `x[63]^y[63]`, even when `z` is an infinity of the other sign. `invalid_o` is 0.
- R8: When the product is zero, an infinite `z` gives infinity with `z`'s sign. Any other `z` is returned unchanged. `invalid_o` is 0.
- R9: When both multiplicands are finite and nonzero:
  - a quiet-NaN `z` is returned unchanged;
  - an infinite `z` gives infinity with `z`'s sign;
  - otherwise `compute_o` = 1 and `result_o` = 0.
- R10: `compute_o` and `invalid_o` are never both 1. The three normalize flags are 0 whenever `compute_o` is 0. When `compute_o` is 1, each flag is 1 exactly when its operand is subnormal.
- R11: With `FLUSH_SUB` = 1, a subnormal operand behaves as a zero of the same sign in every rule above, and all normalize flags stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 64 | First multiplicand, raw encoding |
| y_i | input | 64 | Second multiplicand, raw encoding |
| z_i | input | 64 | Addend, raw encoding |
| result_o | output | 64 | Resolved special result; 0 when `compute_o` is 1 |
| invalid_o | output | 1 | Invalid-operation flag |
| compute_o | output | 1 | Full arithmetic is required |
| norm_x_o | output | 1 | `x` needs normalizing before the arithmetic |
| norm_y_o | output | 1 | `y` needs normalizing before the arithmetic |
| norm_z_o | output | 1 | `z` needs normalizing before the arithmetic |

## Verification
Random triples pick each operand's class uniformly from all six classes before filling in random signs and payloads, so every pairing of classes and all three NaN priority positions are reached. This separates a wrong precedence between `x`, `y` and `z` from a wrong quieting bit. Directed triples cover the cases that random picks seldom land on with the right signs:
- infinity times zero with a quiet and with an ordinary addend, which separates indefinite from pass-through;
- two infinities against an addend of the opposite sign, which shows that the product's sign wins;
- both multiplicands signaling, which shows that `x` wins;
- subnormal multiplicands, which exercise the normalize flags.

Each triple is applied to a default instance and to a flush-subnormal instance at the same time, so the two variants are compared on identical input.

// File: rtl/fma_spec_pkg.sv
package fma_spec_pkg;

   // Operand classes seen by the resolver
   typedef enum logic [2:0] {
      CL_ZERO = 3'd0,
      CL_NORM = 3'd1,
      CL_SUB  = 3'd2,
      CL_INF  = 3'd3,
      CL_QNAN = 3'd4,
      CL_SNAN = 3'd5
   } opcls_e;

   // Which value the result multiplexer drives
   typedef enum logic [3:0] {
      SEL_COMPUTE  = 4'd0,
      SEL_QUIET_Z  = 4'd1,
      SEL_QUIET_X  = 4'd2,
      SEL_QUIET_Y  = 4'd3,
      SEL_PASS_X   = 4'd4,
      SEL_PASS_Y   = 4'd5,
      SEL_PASS_Z   = 4'd6,
      SEL_INDEF    = 4'd7,
      SEL_INF_PROD = 4'd8,
      SEL_INF_Z    = 4'd9
   } rsel_e;

   // Operand slots
   localparam int OPND_X   = 0;
   localparam int OPND_Y   = 1;
   localparam int OPND_Z   = 2;
   localparam int OPND_CNT = 3;

   function automatic logic cls_is_inf(opcls_e c);
      return c == CL_INF;
   endfunction

   function automatic logic cls_is_zero(opcls_e c);
      return c == CL_ZERO;
   endfunction

   function automatic logic cls_is_snan(opcls_e c);
      return c == CL_SNAN;
   endfunction

   function automatic logic cls_is_qnan(opcls_e c);
      return c == CL_QNAN;
   endfunction

endpackage

// File: rtl/fma_opnd_classify.sv
module fma_opnd_classify
   import fma_spec_pkg::*;
#(
   parameter int EXP_W     = 11,
   parameter int FRAC_W    = 52,
   parameter bit FLUSH_SUB = 1'b0
) (
   input  logic [EXP_W+FRAC_W:0] raw_i,
   output opcls_e                cls_o,
   output logic                  sign_o,
   output logic [EXP_W+FRAC_W:0] eff_o
);

   localparam int W     = 1 + EXP_W + FRAC_W;
   localparam int QBIT  = FRAC_W - 1;
   localparam int EXP_L = FRAC_W;
   localparam int EXP_H = FRAC_W + EXP_W - 1;

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_all1;
   logic              exp_all0;
   logic              frac_nz;
   opcls_e            base_cls;

   assign exp_f    = raw_i[EXP_H:EXP_L];
   assign frac_f   = raw_i[FRAC_W-1:0];
   assign exp_all1 = &exp_f;
   assign exp_all0 = ~|exp_f;
   assign frac_nz  = |frac_f;
   assign sign_o   = raw_i[W-1];

   // Class from the raw fields, before any flush option
   always_comb begin
      if (exp_all1) begin
         if (!frac_nz)           base_cls = CL_INF;
         else if (frac_f[QBIT])  base_cls = CL_QNAN;
         else                    base_cls = CL_SNAN;
      end else if (exp_all0) begin
         base_cls = frac_nz ? CL_SUB : CL_ZERO;
      end else begin
         base_cls = CL_NORM;
      end
   end

   generate
      if (FLUSH_SUB) begin : g_flush
         // Subnormals collapse to a signed zero, in class and in value
         always_comb begin
            if (base_cls == CL_SUB) begin
               cls_o = CL_ZERO;
               eff_o = {sign_o, {(W-1){1'b0}}};
            end else begin
               cls_o = base_cls;
               eff_o = raw_i;
            end
         end
      end else begin : g_keep
         assign cls_o = base_cls;
         assign eff_o = raw_i;
      end
   endgenerate

endmodule

// File: rtl/fma_special_decide.sv
module fma_special_decide
   import fma_spec_pkg::*;
(
   input  opcls_e x_cls_i,
   input  opcls_e y_cls_i,
   input  opcls_e z_cls_i,
   output rsel_e  sel_o,
   output logic   invalid_o
);

   logic any_inf_xy;
   logic any_zero_xy;
   logic inf_by_zero;
   logic z_quiet;
   logic z_inf;

   assign any_inf_xy  = cls_is_inf(x_cls_i) | cls_is_inf(y_cls_i);
   assign any_zero_xy = cls_is_zero(x_cls_i) | cls_is_zero(y_cls_i);
   assign inf_by_zero = (cls_is_inf(x_cls_i) & cls_is_zero(y_cls_i)) |
                        (cls_is_zero(x_cls_i) & cls_is_inf(y_cls_i));
   assign z_quiet     = cls_is_qnan(z_cls_i);
   assign z_inf       = cls_is_inf(z_cls_i);

   // Fixed three-operand precedence; earlier tests win
   always_comb begin
      sel_o     = SEL_COMPUTE;
      invalid_o = 1'b0;
      if (cls_is_snan(z_cls_i)) begin
         sel_o     = SEL_QUIET_Z;
         invalid_o = 1'b1;
      end else if (cls_is_snan(x_cls_i)) begin
         sel_o     = SEL_QUIET_X;
         invalid_o = 1'b1;
      end else if (cls_is_snan(y_cls_i)) begin
         sel_o     = SEL_QUIET_Y;
         invalid_o = 1'b1;
      end else if (cls_is_qnan(x_cls_i)) begin
         sel_o = SEL_PASS_X;
      end else if (cls_is_qnan(y_cls_i)) begin
         sel_o = SEL_PASS_Y;
      end else if (inf_by_zero) begin
         if (z_quiet) begin
            sel_o = SEL_PASS_Z;
         end else begin
            sel_o     = SEL_INDEF;
            invalid_o = 1'b1;
         end
      end else if (any_inf_xy) begin
         sel_o = z_quiet ? SEL_PASS_Z : SEL_INF_PROD;
      end else if (any_zero_xy) begin
         sel_o = z_inf ? SEL_INF_Z : SEL_PASS_Z;
      end else if (z_quiet) begin
         sel_o = SEL_PASS_Z;
      end else if (z_inf) begin
         sel_o = SEL_INF_Z;
      end else begin
         sel_o = SEL_COMPUTE;
      end
   end

endmodule

// File: rtl/fma_result_build.sv
module fma_result_build
   import fma_spec_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  rsel_e                 sel_i,
   input  logic [EXP_W+FRAC_W:0] x_eff_i,
   input  logic [EXP_W+FRAC_W:0] y_eff_i,
   input  logic [EXP_W+FRAC_W:0] z_eff_i,
   input  logic                  x_sign_i,
   input  logic                  y_sign_i,
   input  logic                  z_sign_i,
   output logic [EXP_W+FRAC_W:0] result_o
);

   localparam int W = 1 + EXP_W + FRAC_W;
   localparam logic [W-1:0] QMASK   = {{(W-1){1'b0}}, 1'b1} << (FRAC_W - 1);
   localparam logic [W-1:0] INF_MAG = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
   localparam logic [W-1:0] INDEF   = INF_MAG | QMASK;

   function automatic logic [W-1:0] signed_inf(input logic s);
      return {s, INF_MAG[W-2:0]};
   endfunction

   always_comb begin
      unique case (sel_i)
         SEL_QUIET_Z:  result_o = z_eff_i | QMASK;
         SEL_QUIET_X:  result_o = x_eff_i | QMASK;
         SEL_QUIET_Y:  result_o = y_eff_i | QMASK;
         SEL_PASS_X:   result_o = x_eff_i;
         SEL_PASS_Y:   result_o = y_eff_i;
         SEL_PASS_Z:   result_o = z_eff_i;
         SEL_INDEF:    result_o = INDEF;
         SEL_INF_PROD: result_o = signed_inf(x_sign_i ^ y_sign_i);
         SEL_INF_Z:    result_o = signed_inf(z_sign_i);
         default:      result_o = '0;
      endcase
   end

endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
   import fma_spec_pkg::*;
#(
   parameter int EXP_W     = 11,
   parameter int FRAC_W    = 52,
   parameter bit FLUSH_SUB = 1'b0
) (
   input  logic [EXP_W+FRAC_W:0] x_i,
   input  logic [EXP_W+FRAC_W:0] y_i,
   input  logic [EXP_W+FRAC_W:0] z_i,
   output logic [EXP_W+FRAC_W:0] result_o,
   output logic                  invalid_o,
   output logic                  compute_o,
   output logic                  norm_x_o,
   output logic                  norm_y_o,
   output logic                  norm_z_o
);

   localparam int W = 1 + EXP_W + FRAC_W;

   // Elaboration-time parameter checks
   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fma_special_resolve: EXP_W must be at least 2");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("fma_special_resolve: FRAC_W must be at least 2");
      end
   endgenerate

   logic [W-1:0] opnd_raw  [OPND_CNT];
   logic [W-1:0] opnd_eff  [OPND_CNT];
   opcls_e       opnd_cls  [OPND_CNT];
   logic         opnd_sign [OPND_CNT];
   logic [OPND_CNT-1:0] opnd_sub;
   rsel_e        sel;
   logic         compute;

   assign opnd_raw[OPND_X] = x_i;
   assign opnd_raw[OPND_Y] = y_i;
   assign opnd_raw[OPND_Z] = z_i;

   generate
      for (genvar gi = 0; gi < OPND_CNT; gi++) begin : g_cls
         fma_opnd_classify #(
            .EXP_W     (EXP_W),
            .FRAC_W    (FRAC_W),
            .FLUSH_SUB (FLUSH_SUB)
         ) cls_i (
            .raw_i  (opnd_raw[gi]),
            .cls_o  (opnd_cls[gi]),
            .sign_o (opnd_sign[gi]),
            .eff_o  (opnd_eff[gi])
         );
         assign opnd_sub[gi] = (opnd_cls[gi] == CL_SUB);
      end
   endgenerate

   fma_special_decide decide_i (
      .x_cls_i   (opnd_cls[OPND_X]),
      .y_cls_i   (opnd_cls[OPND_Y]),
      .z_cls_i   (opnd_cls[OPND_Z]),
      .sel_o     (sel),
      .invalid_o (invalid_o)
   );

   fma_result_build #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
   ) build_i (
      .sel_i    (sel),
      .x_eff_i  (opnd_eff[OPND_X]),
      .y_eff_i  (opnd_eff[OPND_Y]),
      .z_eff_i  (opnd_eff[OPND_Z]),
      .x_sign_i (opnd_sign[OPND_X]),
      .y_sign_i (opnd_sign[OPND_Y]),
      .z_sign_i (opnd_sign[OPND_Z]),
      .result_o (result_o)
   );

   assign compute   = (sel == SEL_COMPUTE);
   assign compute_o = compute;
   assign norm_x_o  = compute & opnd_sub[OPND_X];
   assign norm_y_o  = compute & opnd_sub[OPND_Y];
   assign norm_z_o  = compute & opnd_sub[OPND_Z];

endmodule

// File: rtl/fma_special_resolve_chk.sv
module fma_special_resolve_chk #(
   parameter int EXP_W     = 11,
   parameter int FRAC_W    = 52,
   parameter bit FLUSH_SUB = 1'b0
) (
   input logic [EXP_W+FRAC_W:0] x_i,
   input logic [EXP_W+FRAC_W:0] y_i,
   input logic [EXP_W+FRAC_W:0] z_i,
   input logic [EXP_W+FRAC_W:0] result_o,
   input logic                  invalid_o,
   input logic                  compute_o,
   input logic                  norm_x_o,
   input logic                  norm_y_o,
   input logic                  norm_z_o
);

   localparam int W = 1 + EXP_W + FRAC_W;
   localparam logic [W-1:0] QMASK = {{(W-1){1'b0}}, 1'b1} << (FRAC_W - 1);

   function automatic logic top_exp(input logic [W-1:0] v);
      return &v[W-2:FRAC_W];
   endfunction
   function automatic logic nan_of(input logic [W-1:0] v);
      return top_exp(v) && (|v[FRAC_W-1:0]);
   endfunction
   function automatic logic snan_of(input logic [W-1:0] v);
      return nan_of(v) && !v[FRAC_W-1];
   endfunction
   function automatic logic inf_of(input logic [W-1:0] v);
      return top_exp(v) && !(|v[FRAC_W-1:0]);
   endfunction
   function automatic logic zero_of(input logic [W-1:0] v);
      return (~|v[W-2:FRAC_W]) && (FLUSH_SUB || !(|v[FRAC_W-1:0]));
   endfunction

   always_comb begin
      // R10
      compute_invalid_excl_chk: assert (!(compute_o && invalid_o))
         else $error("compute and invalid both high");
      // R10
      norm_gated_chk: assert (compute_o || !(norm_x_o || norm_y_o || norm_z_o))
         else $error("normalize flag without compute");
      // R2
      zsnan_first_chk: assert (!snan_of(z_i) ||
                               (invalid_o && !compute_o && result_o == (z_i | QMASK)))
         else $error("signaling addend not resolved first");
      // R3
      xsnan_quiet_chk: assert (!(snan_of(x_i) && !snan_of(z_i)) ||
                               (invalid_o && result_o == (x_i | QMASK)))
         else $error("signaling x not quieted");
      // R6
      invalid_is_qnan_chk: assert (!invalid_o ||
                                   (nan_of(result_o) && result_o[FRAC_W-1]))
         else $error("invalid without quiet NaN result");
      // R9
      compute_operands_chk: assert (!compute_o ||
            (!top_exp(x_i) && !top_exp(y_i) && !top_exp(z_i) &&
             !zero_of(x_i) && !zero_of(y_i) && result_o == '0))
         else $error("compute raised with a special operand");
      // R7
      inf_inf_sign_chk: assert (!(inf_of(x_i) && inf_of(y_i) && !nan_of(z_i)) ||
            (result_o == {x_i[W-1] ^ y_i[W-1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}}))
         else $error("infinite product sign wrong");
   end

endmodule

bind fma_special_resolve fma_special_resolve_chk #(
   .EXP_W     (EXP_W),
   .FRAC_W    (FRAC_W),
   .FLUSH_SUB (FLUSH_SUB)
) chk_i (
   .x_i       (x_i),
   .y_i       (y_i),
   .z_i       (z_i),
   .result_o  (result_o),
   .invalid_o (invalid_o),
   .compute_o (compute_o),
   .norm_x_o  (norm_x_o),
   .norm_y_o  (norm_y_o),
   .norm_z_o  (norm_z_o)
);

// File: tb/fma_special_resolve_tb.sv
module fma_special_resolve_tb_top;

   localparam int CLK_P = 10;
   localparam int NRAND = 1500;

   localparam logic [63:0] QB    = 64'h0008_0000_0000_0000;
   localparam logic [63:0] INDEF = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;

   logic clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic [63:0] x, y, z;
   logic [63:0] r0, r1;
   logic inv0, inv1, cmp0, cmp1;
   logic nx0, ny0, nz0, nx1, ny1, nz1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   fma_special_resolve #(.FLUSH_SUB(1'b0)) dut_i (
      .x_i(x), .y_i(y), .z_i(z), .result_o(r0), .invalid_o(inv0),
      .compute_o(cmp0), .norm_x_o(nx0), .norm_y_o(ny0), .norm_z_o(nz0));

   fma_special_resolve #(.FLUSH_SUB(1'b1)) dut_flush_i (
      .x_i(x), .y_i(y), .z_i(z), .result_o(r1), .invalid_o(inv1),
      .compute_o(cmp1), .norm_x_o(nx1), .norm_y_o(ny1), .norm_z_o(nz1));

   // Class codes of the bench: 0 zero,1 normal,2 sub,3 inf,4 qnan,5 snan (R1)
   function automatic int cls_of(input logic [63:0] v, input bit fl);
      logic [10:0] e = v[62:52];
      logic [51:0] f = v[51:0];
      if (e == 11'h7FF) return (f == 0) ? 3 : (f[51] ? 4 : 5);
      if (e == 0) return (f == 0 || fl) ? 0 : 2;
      return 1;
   endfunction

   function automatic logic [63:0] eff_of(input logic [63:0] v, input bit fl);
      if (fl && v[62:52] == 0) return {v[63], 63'd0};
      return v;
   endfunction

   // Reference model written from the requirements
   task automatic model(input logic [63:0] a, b, c, input bit fl,
                        output logic [63:0] er, output logic ei, ec,
                        output logic [2:0] en, output string tag);
      int ca = cls_of(a, fl), cb = cls_of(b, fl), cc = cls_of(c, fl);
      logic [63:0] ea = eff_of(a, fl), eb = eff_of(b, fl), ez = eff_of(c, fl);
      er = '0; ei = 0; ec = 0; en = 3'b000;
      if (cc == 5)                 begin er = ez | QB; ei = 1; tag = "R2"; end
      else if (ca == 5)            begin er = ea | QB; ei = 1; tag = "R3"; end
      else if (cb == 5)            begin er = eb | QB; ei = 1; tag = "R4"; end
      else if (ca == 4)            begin er = ea; tag = "R5"; end
      else if (cb == 4)            begin er = eb; tag = "R5"; end
      else if ((ca == 3 && cb == 0) || (ca == 0 && cb == 3)) begin
         tag = "R6";
         if (cc == 4) er = ez; else begin er = INDEF; ei = 1; end
      end else if (ca == 3 || cb == 3) begin
         tag = "R7";
         er = (cc == 4) ? ez : {a[63] ^ b[63], PINF[62:0]};
      end else if (ca == 0 || cb == 0) begin
         tag = "R8";
         er = (cc == 3) ? {c[63], PINF[62:0]} : ez;
      end else begin
         tag = "R9";
         if (cc == 4) er = ez;
         else if (cc == 3) er = {c[63], PINF[62:0]};
         else begin
            ec = 1; tag = "R10";
            en = {ca == 2, cb == 2, cc == 2};
         end
      end
      if (fl) tag = {tag, "/R11"};
   endtask

   function automatic logic [63:0] mk(input int c);
      logic s = 1'($urandom_range(0, 1));
      logic [51:0] f = {20'($urandom), $urandom};
      case (c)
         0: return {s, 63'd0};
         1: return {s, 11'($urandom_range(1, 2046)), f};
         2: return {s, 11'd0, f | 52'd1};
         3: return {s, 11'h7FF, 52'd0};
         4: return {s, 11'h7FF, 1'b1, f[50:0]};
         default: return {s, 11'h7FF, 1'b0, f[50:1], 1'b1};
      endcase
   endfunction

   task automatic cmp_one(input logic [63:0] ar, input logic ai, ac,
                          input logic [2:0] an, input bit fl);
      logic [63:0] er; logic ei, ec; logic [2:0] en; string tag;
      model(x, y, z, fl, er, ei, ec, en, tag);
      checks++;
      if (ar !== er || ai !== ei || ac !== ec || an !== en) begin
         fails++;
         $display("FAIL %s flush=%0d x=%h y=%h z=%h actual res=%h inv=%b cmp=%b nrm=%b expected res=%h inv=%b cmp=%b nrm=%b",
                  tag, fl, x, y, z, ar, ai, ac, an, er, ei, ec, en);
      end
   endtask

   task automatic apply(input logic [63:0] a, b, c);
      @(posedge clk);
      x = a; y = b; z = c;
      @(negedge clk);
      cmp_one(r0, inv0, cmp0, {nx0, ny0, nz0}, 1'b0);
      cmp_one(r1, inv1, cmp1, {nx1, ny1, nz1}, 1'b1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      x = '0; y = '0; z = '0;
      // R8: all-zero inputs give +0 with no flags
      apply(64'd0, 64'd0, 64'd0);
      // R6: inf x zero, ordinary addend -> indefinite; quiet addend passes
      apply(PINF, 64'd0, ONE);
      apply({1'b1, PINF[62:0]}, 64'd0, 64'h7FF8_0000_0000_1234);
      apply(64'd0, PINF, ONE);
      // R7: product sign wins over opposite infinite addend
      apply(PINF, PINF, {1'b1, PINF[62:0]});
      apply({1'b1, PINF[62:0]}, ONE, PINF);
      // R3: both multiplicands signaling -> x
      apply(64'h7FF0_0000_0000_0001, 64'h7FF0_0000_0000_0002, ONE);
      // R4: quiet x, signaling y -> quiet y
      apply(64'h7FF8_0000_0000_0003, 64'h7FF0_0000_0000_0004, ONE);
      // R2: signaling addend beats signaling x
      apply(64'h7FF0_0000_0000_0005, ONE, 64'hFFF0_0000_0000_0006);
      // R5: quiet x over quiet y and quiet z
      apply(64'h7FF8_0000_0000_0007, 64'hFFF8_0000_0000_0008, 64'h7FF8_0000_0000_0009);
      // R8: zero product with infinite addend
      apply(ONE, 64'h8000_0000_0000_0000, {1'b1, PINF[62:0]});
      // R9/R10/R11: subnormal operands in the compute path
      apply(64'h0000_0000_0000_0010, ONE, 64'h8000_0000_0000_0020);
      apply(64'h0000_0000_0000_0010, PINF, ONE);
      // R9: finite product with quiet and infinite addend
      apply(ONE, ONE, 64'h7FF8_0000_0000_0001);
      apply(ONE, ONE, {1'b1, PINF[62:0]});
      for (int i = 0; i < NRAND; i++) begin
         apply(mk($urandom_range(0, 5)), mk($urandom_range(0, 5)), mk($urandom_range(0, 5)));
      end
      finish_run();
   end

endmodule